// File: doc/BRIEF.md
# USB Device-Mode State and Bus-Reset Sequencer

This block is the control core for the device side of a full/low-speed USB controller. It keeps the device-mode top state (Reset, Idle, Active). The state depends on the macro enable, on the role input (device or host) and on VBus presence. From that state it drives the pull-up request onto D+ or D-, according to the speed select and the detach control.

While the device is Active, the block watches the sampled line for SE0. SE0 held long enough counts as a bus reset. The block then issues a fixed chain of single-cycle actions, one per cycle:

1. Freeze the macro clock.
2. Clear the device-mode registers.
3. Free the endpoint banks.
4. Force detach.
5. Disable every endpoint except endpoint 0, and reset endpoint 0.
6. Clear the endpoint-0 data toggle.

One cycle after the last action, it sets a sticky end-of-reset flag. Software clears that flag by writing a 1.

Software can write the detach bit, the clock freeze bit and the endpoint enable mask through simple write strobes. A bus-reset action overrides a software write made in the same cycle.

Top module: `usb_dev_seq`

## Requirements
- R1: After hardware reset (`rstN` low), the outputs are as follows: `devState`=0 (Reset), both pull-ups off, `clkFreeze`=1, `detachOut`=1, `epEnable`=7'b0000001 and `eorFlag`=0.
- R2: From Reset, `devState` becomes 1 (Idle) one clock after `macroEn`=1 and `roleDevice`=1 are sampled. It stays 0 otherwise.
- R3: From any state, `devState` becomes 0 one clock after `macroEn`=0 or `roleDevice`=0 is sampled.
- R4: Idle moves to Active (`devState`=2) one clock after `vbusOk`=1 is sampled. Active returns to Idle one clock after `vbusOk`=0 is sampled.
- R5: The pull-up request is combinational. It is raised only when `devState`!=0, `detachOut`=0 and `vbusOk`=1. It appears on `dpPullUp` when `lowSpeed`=0 and on `dmPullUp` when `lowSpeed`=1, and the two are never high together.
- R6: In Active, a bus reset is recognised at the SE0_CLKS-th consecutive clock edge that samples `lineSe0`=1. SE0_CLKS = ceil(2.5 × CLK_MHZ). A shorter SE0 run has no effect.
- R7: Once a bus reset is recognised at edge N, the actions follow on consecutive cycles:
  - `clkFreeze` is 1 from edge N+1.
  - `regClrPulse` is high between edges N+1 and N+2.
  - `bankFreePulse` is high between edges N+2 and N+3.
  - `detachOut` is 1 from edge N+4.
  - `ep0RstPulse` is high between edges N+4 and N+5.
  - `ep0TglClrPulse` is high between edges N+5 and N+6.
  - At most one of the four pulse outputs is high in any cycle.
- R8: A bus reset leaves `epEnable`=7'b0000001 from edge N+5. Bit 0 is endpoint 0 and bits 1..6 are the six further endpoints. This overrides any software write made in the same cycle.
- R9: One SE0 episode starts the action chain only once, however long SE0 lasts. A new episode needs `lineSe0` to go low first.
- R10: `eorFlag` becomes 1 from edge N+7 and then holds until an edge that samples `eorClr`=1. When a set and a clear fall in the same cycle, the set wins.
- R11: Software writes take effect at the next edge:
  - `detachWr` loads `detachVal` into `detachOut`.
  - `frzWr` loads `frzVal` into `clkFreeze`.
  - `epWr` loads `epVal` into `epEnable`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| macroEn | input | 1 | Macro enable |
| roleDevice | input | 1 | Role input, 1 = device, 0 = host |
| vbusOk | input | 1 | VBus present |
| lowSpeed | input | 1 | Speed select, 1 = low speed |
| lineSe0 | input | 1 | Sampled line is SE0 |
| detachWr | input | 1 | Software write strobe for the detach bit |
| detachVal | input | 1 | Detach value to write |
| frzWr | input | 1 | Software write strobe for the clock freeze bit |
| frzVal | input | 1 | Freeze value to write |
| epWr | input | 1 | Software write strobe for the endpoint mask |
| epVal | input | 7 | Endpoint mask value to write |
| eorClr | input | 1 | Write-one clear of the end-of-reset flag |
| devState | output | 2 | Top state: 0 Reset, 1 Idle, 2 Active |
| dpPullUp | output | 1 | Pull-up request on D+ |
| dmPullUp | output | 1 | Pull-up request on D- |
| clkFreeze | output | 1 | Macro clock freeze request |
| detachOut | output | 1 | Effective detach bit |
| regClrPulse | output | 1 | Device register clear pulse |
| bankFreePulse | output | 1 | Endpoint bank de-allocate pulse |
| ep0RstPulse | output | 1 | Endpoint 0 reset pulse |
| ep0TglClrPulse | output | 1 | Endpoint 0 data-toggle clear pulse |
| epEnable | output | 7 | Endpoint enable mask, bit 0 is endpoint 0 |
| eorFlag | output | 1 | End-of-reset interrupt flag |

## Verification
State changes and software writes are due one edge after the inputs that cause them. The bench therefore drives inputs, waits one rising edge and samples 2 ns later. The pull-up outputs are combinational and are checked in that same window.

The bus-reset chain is timed from the SE0_CLKS-th edge that sees SE0. The bench counts each edge after that one and checks each action exactly in its due cycle, so a pulse that is one cycle early or late fails. The end-of-reset flag is checked low at edge N+6 and high at N+7. The same-cycle set/clear case holds the clear high across the set.

// File: rtl/usb_dev_seq_pkg.sv
package usb_dev_seq_pkg;
  localparam int EP_COUNT = 7;

  typedef enum logic [1:0] {
    ST_RESET  = 2'd0,
    ST_IDLE   = 2'd1,
    ST_ACTIVE = 2'd2
  } devStateT;

  typedef struct packed {
    logic freeze;
    logic regClr;
    logic bankFree;
    logic detach;
    logic epDisable;
    logic tglClr;
    logic eorSet;
  } seqStrobeT;
endpackage

// File: rtl/usb_dev_seq_ctrl.sv
module usb_dev_seq_ctrl
  import usb_dev_seq_pkg::*;
#(
  parameter int SE0_CLKS = 120
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      macroEn,
  input  logic      roleDevice,
  input  logic      vbusOk,
  input  logic      lineSe0,
  output devStateT  state,
  output seqStrobeT strobe
);
  localparam int CNT_W = $clog2(SE0_CLKS + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SE0_CLKS - 1);
  localparam logic [2:0] STEP_LAST = 3'd7;

  logic [CNT_W-1:0] se0Cnt;
  logic             se0Fired;
  logic [2:0]       step;
  logic             busReset;

  // top state machine
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_RESET;
    end else if (!macroEn || !roleDevice) begin
      state <= ST_RESET;
    end else begin
      unique case (state)
        ST_RESET:  state <= ST_IDLE;
        ST_IDLE:   if (vbusOk) state <= ST_ACTIVE;
        ST_ACTIVE: if (!vbusOk) state <= ST_IDLE;
        default:   state <= ST_RESET;
      endcase
    end
  end

  // SE0 duration detector, one trigger per episode
  assign busReset = (state == ST_ACTIVE) && lineSe0 && !se0Fired && (se0Cnt == CNT_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      se0Cnt   <= '0;
      se0Fired <= 1'b0;
    end else if (state != ST_ACTIVE || !lineSe0) begin
      se0Cnt   <= '0;
      se0Fired <= 1'b0;
    end else if (busReset) begin
      se0Fired <= 1'b1;
    end else if (!se0Fired) begin
      se0Cnt <= se0Cnt + 1'b1;
    end
  end

  // action chain: once started it runs to completion
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      step <= '0;
    end else if (step != 3'd0) begin
      step <= (step == STEP_LAST) ? 3'd0 : step + 3'd1;
    end else if (busReset) begin
      step <= 3'd1;
    end
  end

  always_comb begin
    strobe           = '0;
    strobe.freeze    = (step == 3'd1);
    strobe.regClr    = (step == 3'd2);
    strobe.bankFree  = (step == 3'd3);
    strobe.detach    = (step == 3'd4);
    strobe.epDisable = (step == 3'd5);
    strobe.tglClr    = (step == 3'd6);
    strobe.eorSet    = (step == 3'd7);
  end
endmodule

// File: rtl/usb_dev_seq_dp.sv
module usb_dev_seq_dp
  import usb_dev_seq_pkg::*;
#(
  parameter int EP_N = EP_COUNT
) (
  input  logic            clk,
  input  logic            rstN,
  input  devStateT        state,
  input  seqStrobeT       strobe,
  input  logic            vbusOk,
  input  logic            lowSpeed,
  input  logic            detachWr,
  input  logic            detachVal,
  input  logic            frzWr,
  input  logic            frzVal,
  input  logic            epWr,
  input  logic [EP_N-1:0] epVal,
  input  logic            eorClr,
  output logic            dpPullUp,
  output logic            dmPullUp,
  output logic            clkFreeze,
  output logic            detachOut,
  output logic            regClrPulse,
  output logic            bankFreePulse,
  output logic            ep0RstPulse,
  output logic            ep0TglClrPulse,
  output logic [EP_N-1:0] epEnable,
  output logic            eorFlag
);
  localparam logic [EP_N-1:0] EP_DEFAULT = EP_N'(1);

  logic pullOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkFreeze <= 1'b1;
      detachOut <= 1'b1;
      epEnable  <= EP_DEFAULT;
      eorFlag   <= 1'b0;
    end else begin
      if (strobe.freeze)  clkFreeze <= 1'b1;
      else if (frzWr)     clkFreeze <= frzVal;

      if (strobe.detach)  detachOut <= 1'b1;
      else if (detachWr)  detachOut <= detachVal;

      if (strobe.epDisable) epEnable <= EP_DEFAULT;
      else if (epWr)        epEnable <= epVal;

      if (strobe.eorSet)  eorFlag <= 1'b1;
      else if (eorClr)    eorFlag <= 1'b0;
    end
  end

  assign pullOn         = (state != ST_RESET) && !detachOut && vbusOk;
  assign dpPullUp       = pullOn && !lowSpeed;
  assign dmPullUp       = pullOn && lowSpeed;
  assign regClrPulse    = strobe.regClr;
  assign bankFreePulse  = strobe.bankFree;
  assign ep0RstPulse    = strobe.epDisable;
  assign ep0TglClrPulse = strobe.tglClr;
endmodule

// File: rtl/usb_dev_seq.sv
module usb_dev_seq
  import usb_dev_seq_pkg::*;
#(
  parameter int CLK_MHZ  = 48,
  parameter int SE0_CLKS = (CLK_MHZ * 5 + 1) / 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       macroEn,
  input  logic       roleDevice,
  input  logic       vbusOk,
  input  logic       lowSpeed,
  input  logic       lineSe0,
  input  logic       detachWr,
  input  logic       detachVal,
  input  logic       frzWr,
  input  logic       frzVal,
  input  logic       epWr,
  input  logic [6:0] epVal,
  input  logic       eorClr,
  output logic [1:0] devState,
  output logic       dpPullUp,
  output logic       dmPullUp,
  output logic       clkFreeze,
  output logic       detachOut,
  output logic       regClrPulse,
  output logic       bankFreePulse,
  output logic       ep0RstPulse,
  output logic       ep0TglClrPulse,
  output logic [6:0] epEnable,
  output logic       eorFlag
);
  devStateT  state;
  seqStrobeT strobe;

  usb_dev_seq_ctrl #(.SE0_CLKS(SE0_CLKS)) uCtrl (
    .clk(clk), .rstN(rstN), .macroEn(macroEn), .roleDevice(roleDevice),
    .vbusOk(vbusOk), .lineSe0(lineSe0), .state(state), .strobe(strobe)
  );

  usb_dev_seq_dp #(.EP_N(EP_COUNT)) uDp (
    .clk(clk), .rstN(rstN), .state(state), .strobe(strobe),
    .vbusOk(vbusOk), .lowSpeed(lowSpeed),
    .detachWr(detachWr), .detachVal(detachVal),
    .frzWr(frzWr), .frzVal(frzVal),
    .epWr(epWr), .epVal(epVal), .eorClr(eorClr),
    .dpPullUp(dpPullUp), .dmPullUp(dmPullUp),
    .clkFreeze(clkFreeze), .detachOut(detachOut),
    .regClrPulse(regClrPulse), .bankFreePulse(bankFreePulse),
    .ep0RstPulse(ep0RstPulse), .ep0TglClrPulse(ep0TglClrPulse),
    .epEnable(epEnable), .eorFlag(eorFlag)
  );

  assign devState = state;
endmodule

// File: rtl/usb_dev_seq_chk.sv
module usb_dev_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       macroEn,
  input logic       roleDevice,
  input logic       vbusOk,
  input logic       eorClr,
  input logic [1:0] devState,
  input logic       dpPullUp,
  input logic       dmPullUp,
  input logic       clkFreeze,
  input logic       detachOut,
  input logic       regClrPulse,
  input logic       bankFreePulse,
  input logic       ep0RstPulse,
  input logic       ep0TglClrPulse,
  input logic [6:0] epEnable,
  input logic       eorFlag
);
  a_r3_leave_to_reset: assert property (@(posedge clk) disable iff (!rstN)
    (!macroEn || !roleDevice) |=> devState == 2'd0);

  a_r2_reset_to_idle: assert property (@(posedge clk) disable iff (!rstN)
    (devState == 2'd0 && macroEn && roleDevice) |=> devState == 2'd1);

  a_r5_pull_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(dpPullUp && dmPullUp));

  a_r5_pull_needs_vbus: assert property (@(posedge clk) disable iff (!rstN)
    (dpPullUp || dmPullUp) |-> (vbusOk && !detachOut && devState != 2'd0));

  a_r7_pulse_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({regClrPulse, bankFreePulse, ep0RstPulse, ep0TglClrPulse}));

  a_r7_frozen_at_clear: assert property (@(posedge clk) disable iff (!rstN)
    regClrPulse |-> clkFreeze);

  a_r7_clear_then_free: assert property (@(posedge clk) disable iff (!rstN)
    regClrPulse |=> bankFreePulse);

  a_r7_free_then_detach: assert property (@(posedge clk) disable iff (!rstN)
    bankFreePulse |=> ##1 (detachOut && ep0RstPulse));

  a_r8_mask_after_disable: assert property (@(posedge clk) disable iff (!rstN)
    ep0RstPulse |=> (epEnable == 7'd1 && ep0TglClrPulse));

  a_r10_set_after_toggle: assert property (@(posedge clk) disable iff (!rstN)
    ep0TglClrPulse |=> ##1 eorFlag);

  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (eorFlag && !eorClr) |=> eorFlag);
endmodule

bind usb_dev_seq usb_dev_seq_chk uChk (
  .clk(clk), .rstN(rstN), .macroEn(macroEn), .roleDevice(roleDevice),
  .vbusOk(vbusOk), .eorClr(eorClr), .devState(devState),
  .dpPullUp(dpPullUp), .dmPullUp(dmPullUp), .clkFreeze(clkFreeze),
  .detachOut(detachOut), .regClrPulse(regClrPulse), .bankFreePulse(bankFreePulse),
  .ep0RstPulse(ep0RstPulse), .ep0TglClrPulse(ep0TglClrPulse),
  .epEnable(epEnable), .eorFlag(eorFlag)
);

// File: tb/usb_dev_seq_test.sv
`timescale 1ns/1ps
module usb_dev_seq_test;
  localparam int CLK_MHZ = 4;
  localparam int N = (CLK_MHZ * 5 + 1) / 2;   // 10 SE0 edges

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic macroEn = 0, roleDevice = 0, vbusOk = 0, lowSpeed = 0, lineSe0 = 0;
  logic detachWr = 0, detachVal = 0, frzWr = 0, frzVal = 0, epWr = 0, eorClr = 0;
  logic [6:0] epVal = '0;
  logic [1:0] devState;
  logic dpPullUp, dmPullUp, clkFreeze, detachOut, regClrPulse, bankFreePulse;
  logic ep0RstPulse, ep0TglClrPulse, eorFlag;
  logic [6:0] epEnable;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  usb_dev_seq #(.CLK_MHZ(CLK_MHZ)) uut (.*);

  // {macroEn, roleDevice, vbusOk, lowSpeed, expState[1:0], expDp, expDm}
  localparam int NV = 9;
  localparam logic [7:0] VEC [NV] = '{
    8'b0_0_0_0_00_0_0,
    8'b1_1_0_0_01_0_0,
    8'b1_1_1_0_10_1_0,
    8'b1_1_1_1_10_0_1,
    8'b1_1_0_0_01_0_0,
    8'b1_0_1_0_00_0_0,
    8'b1_1_1_0_01_1_0,
    8'b1_1_1_0_10_1_0,
    8'b0_1_1_0_00_0_0
  };

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write1(input int which, input logic val);
    if (which == 0) begin detachWr = 1; detachVal = val; end
    else begin frzWr = 1; frzVal = val; end
    tick();
    detachWr = 0; frzWr = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #23;
    // R1 reset state
    check("R1 state", devState, 0);
    check("R1 pull", {dpPullUp, dmPullUp}, 0);
    check("R1 freeze", clkFreeze, 1);
    check("R1 detach", detachOut, 1);
    check("R1 epmask", epEnable, 7'h01);
    check("R1 eor", eorFlag, 0);
    rstN = 1;
    tick();
    check("R2 stay reset while disabled", devState, 0);
    // R11 software writes
    write1(0, 1'b0);
    check("R11 detach write", detachOut, 0);
    write1(1, 1'b0);
    check("R11 freeze write", clkFreeze, 0);
    epWr = 1; epVal = 7'h5A; tick(); epWr = 0;
    check("R11 ep write", epEnable, 7'h5A);

    // vector walk: R2 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      {macroEn, roleDevice, vbusOk, lowSpeed} = VEC[i][7:4];
      tick();
      check("R2/R3/R4 state", devState, VEC[i][3:2]);
      check("R5 pullups", {dpPullUp, dmPullUp}, VEC[i][1:0]);
    end

    // reach Active
    macroEn = 1; roleDevice = 1; vbusOk = 1; lowSpeed = 0;
    tick(); tick();
    check("R4 active", devState, 2);
    epWr = 1; epVal = 7'h7F; tick(); epWr = 0;

    // R6 short SE0: N-1 edges then release
    lineSe0 = 1;
    repeat (N - 1) tick();
    lineSe0 = 0;
    begin
      int seen = 0;
      for (int k = 0; k < 10; k++) begin tick(); if (regClrPulse) seen++; end
      check("R6 short SE0 ignored pulses", seen, 0);
    end
    check("R6 short SE0 freeze", clkFreeze, 0);
    check("R6 short SE0 mask", epEnable, 7'h7F);

    // R6 R7 R8 R10 full bus reset; edge N is the last of N ticks
    lineSe0 = 1;
    repeat (N) tick();
    check("R7 N freeze not yet", clkFreeze, 0);
    check("R6 N no clear yet", regClrPulse, 0);
    tick(); // N+1
    check("R7 N+1 freeze", clkFreeze, 1);
    check("R7 N+1 regclr", regClrPulse, 1);
    tick(); // N+2
    check("R7 N+2 bankfree", bankFreePulse, 1);
    check("R7 N+2 regclr low", regClrPulse, 0);
    epWr = 1; epVal = 7'h7E;   // write that strobe at N+4..N+5 must override
    tick(); // N+3
    epWr = 0;
    check("R7 N+3 detach not yet", detachOut, 0);
    check("R5 N+3 pull still on", dpPullUp, 1);
    epWr = 1; epVal = 7'h33;
    tick(); // N+4
    check("R7 N+4 detach", detachOut, 1);
    check("R7 N+4 ep0 reset", ep0RstPulse, 1);
    check("R5 N+4 pull off", {dpPullUp, dmPullUp}, 0);
    tick(); // N+5
    epWr = 0;
    check("R8 N+5 mask", epEnable, 7'h01);
    check("R7 N+5 toggle clear", ep0TglClrPulse, 1);
    tick(); // N+6
    check("R10 N+6 flag low", eorFlag, 0);
    tick(); // N+7
    check("R10 N+7 flag set", eorFlag, 1);

    // R9 long SE0 gives no repeat
    begin
      int seen = 0;
      for (int k = 0; k < 3 * N; k++) begin tick(); if (regClrPulse) seen++; end
      check("R9 no repeat", seen, 0);
    end
    check("R10 flag holds", eorFlag, 1);
    eorClr = 1; tick(); eorClr = 0;
    check("R10 clear", eorFlag, 0);

    // second episode with clear held: set wins, then clear
    lineSe0 = 0; tick();
    write1(0, 1'b0);
    lineSe0 = 1; eorClr = 1;
    repeat (N + 7) tick();
    check("R10 set wins", eorFlag, 1);
    tick();
    check("R10 clear after set", eorFlag, 0);
    eorClr = 0;

    // R3 drop role from Active
    lineSe0 = 0; roleDevice = 0; tick();
    check("R3 host role", devState, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule